// File: doc/BRIEF.md
# Memory Access Guard

This block sits between a soft processor's request port and a single memory port that serves a fixed address map. The map has code memory, data memory (which holds a smaller secrets window), and peripheral I/O. Every processor request carries an address, an access kind and the processor's current privilege level. The guard decides in the same cycle, with no register on the way, whether the request may pass. Allowed requests are forwarded to memory unchanged. Blocked requests are answered at once with an error response and never reach the memory enable or write strobe. The cycle after a blocked handshake, a registered fault flag and a two-bit cause code are raised for a single cycle, for use by trap logic elsewhere.

The policy is fixed when the block is built; no software can program it. Region bases and sizes are parameters. A debug write port, which runs with full privilege, can load code memory so that firmware can be replaced without rebuilding the hardware. Setting the `LOCKDOWN` parameter removes that path from the generated logic. With the path removed, code memory accepts no write from any source.

Both the request side and the memory side use valid/ready handshakes:
- A requester holds its valid signal and its payload stable until it sees ready.
- An allowed request completes when memory raises `mem_ready`, so memory back-pressure reaches the processor directly.
- A faulted request is ready in its first cycle whatever `mem_ready` is.
- The debug port has priority over the processor for the memory port. While debug is forwarded, a processor request that is allowed waits.

Top module: `mem_guard`

## Requirements
- R1: A store to the code region faults with cause 00 at every privilege level. No processor store ever reaches memory with an address in the code region.
- R2: A fetch from any region other than code faults with cause 01 at every privilege level. This covers data, secrets and peripherals. A fetch from code is allowed at every level.
- R3: `req_priv` is decoded as 11 = Machine, 01 = Supervisor, 00 = User. The value 10 gets User rights.
- R4: Loads and stores to the peripheral region pass in Machine and Supervisor. In User they fault with cause 10.
- R5: Loads and stores to the secrets window inside data memory fault with cause 10 in User. Loads and stores to the rest of data memory pass at every level.
- R6: An address outside every region faults with cause 11 for every kind and level. This cause takes priority over all other causes.
- R7: A faulted request sees `req_ready`=1 and `req_err`=1 in the same cycle. It does not drive `mem_valid`, and `req_rdata` is zero.
- R8: An allowed request drives `mem_valid` with its address and data. `mem_write` is high for a store and low for other kinds. `req_ready` follows `mem_ready`, and `req_rdata` carries `mem_rdata`. Kind encoding: 00 fetch, 01 load, 10 and 11 store.
- R9: `fault_o` is 1 in exactly the cycle after a faulted handshake, with `fault_cause` holding that fault's cause. In every other cycle `fault_o` is 0 and `fault_cause` is 00.
- R10: Without lock-down, a debug write whose address is in the code region takes the memory port as a write, with `dbg_ready`=`mem_ready`. An allowed processor request waits during that cycle. A debug write outside code is not forwarded: it gets `dbg_err`=1 and `dbg_ready`=1 in the same cycle.
- R11: With `LOCKDOWN`=1, a debug write never reaches memory. `dbg_err` and `dbg_ready` are both 1 whenever `dbg_valid` is high.
- R12: After reset, `fault_o` is 0 and `fault_cause` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Processor request accepted |
| req_addr | input | ADDR_W | Request address |
| req_kind | input | 2 | 00 fetch, 01 load, 1x store |
| req_priv | input | 2 | Current privilege level |
| req_wdata | input | DATA_W | Store data |
| req_rdata | output | DATA_W | Read data returned to the processor |
| req_err | output | 1 | Error response for a blocked request |
| dbg_valid | input | 1 | Debug write valid |
| dbg_ready | output | 1 | Debug write accepted |
| dbg_addr | input | ADDR_W | Debug write address |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_err | output | 1 | Debug write refused |
| mem_valid | output | 1 | Memory request enable |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| fault_o | output | 1 | Registered one-cycle fault flag |
| fault_cause | output | 2 | Registered cause: 00 code store, 01 non-code fetch, 10 privilege, 11 unmapped |

## Verification
The hardest case to reach from the ports is the collision of a debug write and a processor request in the same cycle. In that cycle the debug write owns the memory port, the processor's own fault handling must still complete, and `mem_ready` must still apply back-pressure. Directed steps raise a code-region debug write together with an allowed processor load, and then together with a processor access that faults. A second instance built with lock-down sees the same stimulus, so both variants are compared cycle for cycle. Random requests aimed at each region's first word, last word and the words just past its end cover the region edges, where the priority of the unmapped cause matters.

// File: rtl/mguard_pkg.sv
package mguard_pkg;

  typedef enum logic [1:0] {
    CAUSE_CODE_WR = 2'b00,
    CAUSE_EXEC    = 2'b01,
    CAUSE_PRIV    = 2'b10,
    CAUSE_UNMAP   = 2'b11
  } cause_e;

  typedef struct packed {
    logic code;
    logic data;
    logic secret;
    logic periph;
  } hit_t;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] PRIV_SUP   = 2'b01;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

  function automatic logic priv_elevated(input logic [1:0] p);
    return (p == PRIV_SUP) || (p == PRIV_MACH);
  endfunction

endpackage

// File: rtl/mguard_decode.sv
module mguard_decode
  import mguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CODE_BASE   = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] CODE_SIZE   = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] DATA_BASE   = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] DATA_SIZE   = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] SECRET_BASE = 32'h1000_3000,
  parameter logic [ADDR_W-1:0] SECRET_SIZE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_SIZE = 32'h0000_1000
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);

  localparam int unsigned NREG = 4;
  localparam logic [NREG-1:0][ADDR_W-1:0] BASES =
    {CODE_BASE, DATA_BASE, SECRET_BASE, PERIPH_BASE};
  localparam logic [NREG-1:0][ADDR_W-1:0] SIZES =
    {CODE_SIZE, DATA_SIZE, SECRET_SIZE, PERIPH_SIZE};

  logic [NREG-1:0] in_rng;

  for (genvar g = 0; g < NREG; g++) begin : g_rng
    logic [ADDR_W-1:0] offs;
    assign offs      = addr - BASES[g];
    assign in_rng[g] = (addr >= BASES[g]) && (offs < SIZES[g]);
  end

  assign hit = hit_t'(in_rng);

endmodule

// File: rtl/mguard_policy.sv
module mguard_policy
  import mguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  hit_t       hit,
  input  logic [1:0] kind,
  input  logic [1:0] priv,
  output logic       fault,
  output cause_e     cause
);

  logic is_fetch, is_store, mapped, elevated;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_store = kind[1];
  assign mapped   = hit.code | hit.data | hit.secret | hit.periph;
  assign elevated = priv_elevated(priv);

  always_comb begin
    fault = 1'b0;
    cause = CAUSE_CODE_WR;
    if (!mapped) begin
      fault = 1'b1;
      cause = CAUSE_UNMAP;
    end else if (hit.code && is_store) begin
      fault = 1'b1;
      cause = CAUSE_CODE_WR;
    end else if (is_fetch && !hit.code) begin
      fault = 1'b1;
      cause = CAUSE_EXEC;
    end else if (!elevated && (hit.periph || hit.secret)) begin
      fault = 1'b1;
      cause = CAUSE_PRIV;
    end
  end

  AST_EXEC_NONCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == 2'b00 && (hit.data || hit.periph) && !hit.code)
      |-> fault) // R2
    else $error("fetch outside code passed");

  AST_USER_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit.periph && kind != 2'b00 && (priv == 2'b00 || priv == 2'b10))
      |-> (fault && cause == CAUSE_PRIV)) // R4
    else $error("user peripheral access passed");

  AST_USER_SECRET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit.secret && kind != 2'b00 && priv[0] == 1'b0)
      |-> fault) // R5
    else $error("user secret access passed");

  AST_UNMAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit == '0) |-> (fault && cause == CAUSE_UNMAP)) // R6
    else $error("unmapped access not flagged");

endmodule

// File: rtl/mguard_dbg.sv
module mguard_dbg #(
  parameter bit          LOCKDOWN = 1'b0,
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] CODE_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] CODE_SIZE = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_valid,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              mem_ready,
  output logic              dbg_use,
  output logic              dbg_ready,
  output logic              dbg_err
);

  if (LOCKDOWN) begin : g_locked
    assign dbg_use   = 1'b0;
    assign dbg_ready = 1'b1;
    assign dbg_err   = dbg_valid;
  end else begin : g_open
    logic [ADDR_W-1:0] offs;
    logic              in_code;
    assign offs      = dbg_addr - CODE_BASE;
    assign in_code   = (dbg_addr >= CODE_BASE) && (offs < CODE_SIZE);
    assign dbg_use   = dbg_valid & in_code;
    assign dbg_err   = dbg_valid & ~in_code;
    assign dbg_ready = dbg_use ? mem_ready : dbg_valid;

    AST_DBG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_valid && !dbg_use) |-> (dbg_ready && dbg_err)) // R10
      else $error("refused debug write not completed");
  end

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mguard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter bit          LOCKDOWN = 1'b0,
  parameter logic [ADDR_W-1:0] CODE_BASE   = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] CODE_SIZE   = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] DATA_BASE   = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] DATA_SIZE   = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] SECRET_BASE = 32'h1000_3000,
  parameter logic [ADDR_W-1:0] SECRET_SIZE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PERIPH_SIZE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_err,
  input  logic              dbg_valid,
  output logic              dbg_ready,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fault_o,
  output logic [1:0]        fault_cause
);

  hit_t   hit;
  logic   pol_fault;
  cause_e pol_cause;
  logic   dbg_use;
  logic   cpu_fault, fwd_cpu;

  mguard_decode #(
    .ADDR_W(ADDR_W),
    .CODE_BASE(CODE_BASE), .CODE_SIZE(CODE_SIZE),
    .DATA_BASE(DATA_BASE), .DATA_SIZE(DATA_SIZE),
    .SECRET_BASE(SECRET_BASE), .SECRET_SIZE(SECRET_SIZE),
    .PERIPH_BASE(PERIPH_BASE), .PERIPH_SIZE(PERIPH_SIZE)
  ) u_dec (
    .addr(req_addr),
    .hit (hit)
  );

  mguard_policy u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .hit      (hit),
    .kind     (req_kind),
    .priv     (req_priv),
    .fault    (pol_fault),
    .cause    (pol_cause)
  );

  mguard_dbg #(
    .LOCKDOWN (LOCKDOWN),
    .ADDR_W   (ADDR_W),
    .CODE_BASE(CODE_BASE),
    .CODE_SIZE(CODE_SIZE)
  ) u_dbg (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_valid(dbg_valid),
    .dbg_addr (dbg_addr),
    .mem_ready(mem_ready),
    .dbg_use  (dbg_use),
    .dbg_ready(dbg_ready),
    .dbg_err  (dbg_err)
  );

  assign cpu_fault = req_valid & pol_fault;
  assign fwd_cpu   = req_valid & ~pol_fault & ~dbg_use;

  assign mem_valid = dbg_use | fwd_cpu;
  assign mem_write = dbg_use | (fwd_cpu & req_kind[1]);
  assign mem_addr  = dbg_use ? dbg_addr  : req_addr;
  assign mem_wdata = dbg_use ? dbg_wdata : req_wdata;

  assign req_ready = cpu_fault | (fwd_cpu & mem_ready);
  assign req_err   = cpu_fault;
  assign req_rdata = fwd_cpu ? mem_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_o     <= 1'b0;
      fault_cause <= 2'b00;
    end else begin
      fault_o     <= cpu_fault;
      fault_cause <= cpu_fault ? pol_cause : 2'b00;
    end
  end

  AST_CODE_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !dbg_valid) |-> !hit.code) // R1
    else $error("store reached code memory");

  AST_BLOCK_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pol_fault && !dbg_valid) |-> (!mem_valid && req_ready)) // R7
    else $error("blocked request forwarded");

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_err && !mem_ready) |-> !req_ready) // R8
    else $error("allowed request completed without memory ready");

  AST_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> fault_o) // R9
    else $error("fault flag missing after blocked request");

  AST_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_err |=> (!fault_o && fault_cause == 2'b00)) // R9
    else $error("fault flag without blocked request");

endmodule

// File: tb/sim_mem_guard.sv
module sim_mem_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CB = 32'h0000_0000, CS = 32'h0000_4000;
  localparam logic [31:0] DB = 32'h1000_0000, DS = 32'h0000_4000;
  localparam logic [31:0] SB = 32'h1000_3000, SS = 32'h0000_1000;
  localparam logic [31:0] PB = 32'h2000_0000, PS = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, dbg_addr = '0, dbg_wdata = '0;
  logic [31:0] mem_rdata = 32'hA5A5_0001;
  logic [1:0] req_kind = '0, req_priv = '0;
  logic dbg_valid = 1'b0, mem_ready = 1'b1;

  logic req_ready, req_err, dbg_ready, dbg_err, mem_valid, mem_write, fault_o;
  logic [31:0] req_rdata, mem_addr, mem_wdata;
  logic [1:0] fault_cause;
  logic l_req_ready, l_req_err, l_dbg_ready, l_dbg_err, l_mem_valid, l_mem_write, l_fault_o;
  logic [31:0] l_req_rdata, l_mem_addr, l_mem_wdata;
  logic [1:0] l_fault_cause;

  int total = 0, bad = 0;
  bit pend_f = 1'b0;
  logic [1:0] pend_c = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_err(req_err),
    .dbg_valid(dbg_valid), .dbg_ready(dbg_ready), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_err(dbg_err), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fault_o(fault_o),
    .fault_cause(fault_cause));

  mem_guard #(.LOCKDOWN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .req_wdata(req_wdata), .req_rdata(l_req_rdata), .req_err(l_req_err),
    .dbg_valid(dbg_valid), .dbg_ready(l_dbg_ready), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_err(l_dbg_err), .mem_valid(l_mem_valid),
    .mem_ready(mem_ready), .mem_write(l_mem_write), .mem_addr(l_mem_addr),
    .mem_wdata(l_mem_wdata), .mem_rdata(mem_rdata), .fault_o(l_fault_o),
    .fault_cause(l_fault_cause));

  function automatic bit in_r(logic [31:0] a, logic [31:0] b, logic [31:0] s);
    return (a >= b) && ((a - b) < s);
  endfunction

  // returns {fault, cause}
  function automatic logic [2:0] ref_chk(logic [31:0] a, logic [1:0] k, logic [1:0] p);
    bit hc = in_r(a, CB, CS), hd = in_r(a, DB, DS), hs = in_r(a, SB, SS), hp = in_r(a, PB, PS);
    bit elev = (p == 2'b11) || (p == 2'b01);
    if (!(hc || hd || hs || hp)) return 3'b111;
    if (hc && k[1]) return 3'b100;
    if (k == 2'b00 && !hc) return 3'b101;
    if (!elev && (hp || hs)) return 3'b110;
    return 3'b000;
  endfunction

  function automatic string tag_of(logic [2:0] r, logic [31:0] a, logic [1:0] p);
    if (!r[2]) return "R8";
    case (r[1:0])
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return (p == 2'b10) ? "R3" : (in_r(a, PB, PS) ? "R4" : "R5");
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [1:0] k, logic [1:0] p, bit mr);
    logic [2:0] r;
    bit f, dbu, fwd;
    string tg;
    @(negedge clk);
    chk(fault_o == pend_f, "R9", {31'd0, fault_o}, {31'd0, pend_f});
    chk(fault_cause == pend_c, "R9", {30'd0, fault_cause}, {30'd0, pend_c});
    req_valid = v; req_addr = a; req_kind = k; req_priv = p; mem_ready = mr;
    req_wdata = $urandom;
    mem_rdata = $urandom;
    #1;
    r = ref_chk(a, k, p);
    f = v && r[2];
    tg = tag_of(r, a, p);
    dbu = dbg_valid && in_r(dbg_addr, CB, CS);
    fwd = v && !r[2] && !dbu;
    chk(req_err == f, tg, {31'd0, req_err}, {31'd0, f});
    chk(mem_valid == (dbu || fwd), f ? "R7" : tg, {31'd0, mem_valid}, {31'd0, dbu || fwd});
    chk(mem_write == (dbu || (fwd && k[1])), "R8", {31'd0, mem_write}, {31'd0, dbu || (fwd && k[1])});
    chk(req_ready == (f || (fwd && mr)), f ? "R7" : "R8", {31'd0, req_ready}, {31'd0, f || (fwd && mr)});
    if (fwd) begin
      chk(mem_addr == a, "R8", mem_addr, a);
      chk(req_rdata == mem_rdata, "R8", req_rdata, mem_rdata);
    end
    if (f) chk(req_rdata == '0, "R7", req_rdata, '0);
    if (f) chk(fault_cause == pend_c, "R9", {30'd0, fault_cause}, {30'd0, pend_c});
    pend_f = f;
    pend_c = f ? r[1:0] : 2'b00;
  endtask

  function automatic logic [31:0] pick_addr();
    int sel = $urandom % 6;
    case (sel)
      0: return CB + ($urandom % (CS + 2));
      1: return DB + ($urandom % (DS + 2));
      2: return SB + ($urandom % (SS + 2));
      3: return PB + ($urandom % (PS + 2));
      4: return (($urandom % 2) != 0) ? (CB + CS - 1) : (PB + PS);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(fault_o == 1'b0, "R12", {31'd0, fault_o}, 32'd0);
    chk(fault_cause == 2'b00, "R12", {30'd0, fault_cause}, 32'd0);

    // directed corners
    step(1, CB + 32'h10, 2'b10, 2'b11, 1);     // R1 machine store to code
    step(1, CB + 32'h20, 2'b11, 2'b00, 1);     // R1 alt store encoding
    step(1, DB + 32'h40, 2'b00, 2'b11, 1);     // R2 fetch from data
    step(1, CB + 32'h40, 2'b00, 2'b00, 1);     // R2 fetch from code by user passes
    step(1, PB + 32'h4,  2'b01, 2'b10, 1);     // R3 priv 10 treated as user
    step(1, PB + 32'h4,  2'b01, 2'b01, 1);     // R4 supervisor peripheral load
    step(1, PB + 32'h8,  2'b10, 2'b00, 1);     // R4 user peripheral store
    step(1, SB,          2'b01, 2'b00, 1);     // R5 user secret load
    step(1, SB - 1,      2'b10, 2'b00, 1);     // R5 user data just below secrets
    step(1, SB + 32'h8,  2'b01, 2'b01, 1);     // R5 supervisor secret load
    step(1, CB + CS,     2'b10, 2'b11, 1);     // R6 past code end
    step(1, PB + PS,     2'b00, 2'b11, 1);     // R6 wins over fetch cause
    step(1, DB + 32'h80, 2'b01, 2'b00, 0);     // R8 back-pressure
    step(1, CB + 32'h80, 2'b10, 2'b00, 0);     // R7 fault ignores memory stall
    step(0, CB + 32'h80, 2'b10, 2'b00, 1);     // idle

    // R10/R11: debug collides with allowed processor load
    dbg_valid = 1'b1; dbg_addr = CB + 32'h100; dbg_wdata = 32'hDEAD_BEEF;
    step(1, DB + 32'h4, 2'b01, 2'b00, 1);
    chk(mem_addr == dbg_addr, "R10", mem_addr, dbg_addr);
    chk(mem_wdata == dbg_wdata, "R10", mem_wdata, dbg_wdata);
    chk(dbg_ready && !dbg_err, "R10", {30'd0, dbg_ready, dbg_err}, 32'd2);
    chk(!req_ready, "R10", {31'd0, req_ready}, 32'd0);
    chk(l_dbg_err && l_dbg_ready, "R11", {30'd0, l_dbg_ready, l_dbg_err}, 32'd3);
    chk(!l_mem_write && l_mem_addr == req_addr, "R11", l_mem_addr, req_addr);
    // debug plus faulting processor store; memory stalled
    step(1, CB + 32'h8, 2'b10, 2'b11, 0);
    chk(!dbg_ready, "R10", {31'd0, dbg_ready}, 32'd0);
    chk(!l_mem_valid && l_dbg_ready, "R11", {30'd0, l_mem_valid, l_dbg_ready}, 32'd1);
    // debug outside code
    dbg_addr = DB + 32'h10;
    step(1, DB + 32'h4, 2'b10, 2'b00, 1);
    chk(dbg_err && dbg_ready, "R10", {30'd0, dbg_ready, dbg_err}, 32'd3);
    chk(mem_addr == req_addr, "R10", mem_addr, req_addr);
    dbg_valid = 1'b0;
    step(0, 32'h0, 2'b00, 2'b00, 1);
    chk(!l_dbg_err, "R11", {31'd0, l_dbg_err}, 32'd0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 8) != 0, pick_addr(), 2'($urandom), 2'($urandom), ($urandom % 4) != 0);
    end
    step(0, 32'h0, 2'b00, 2'b00, 1);
    step(0, 32'h0, 2'b00, 2'b00, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule